// File: doc/BRIEF.md
# PS/2 Host Frame Receiver

This block sits on the host side of a PS/2 link and decodes the frames a keyboard or mouse sends over the open-drain clock and data pair. Both lines are first brought into the system clock domain. Each falling edge of the device clock is then judged by how long it came after the previous accepted edge and after the host's own last transmission. An edge that passes is fed to a frame state machine, which takes one bit from the data line on that edge.

A frame has eleven bits: a low start bit, eight data bits with the least significant bit first, an odd parity bit and a high stop bit. A good frame produces the byte, a one-cycle valid pulse and a parity-error flag. A framing fault clears the partial frame and gives a one-cycle request for the host to send the resend command (0xFE). The same happens when an edge comes too late in mid-frame. A configuration input states whether the host is allowed to write. When it is low, device acknowledge and not-acknowledge bytes get special handling, and a parity fault becomes a hard error. Timing is measured with a one-microsecond tick supplied from outside.

The state machine has four states. S_WAIT_START goes to S_TAKE_DATA on a low start bit. S_TAKE_DATA stays put for data bits 0 to 6 and goes to S_TAKE_PARITY after bit 7. S_TAKE_PARITY goes to S_TAKE_STOP. S_TAKE_STOP goes back to S_WAIT_START, either with a delivery or with a silent drop. The "fail" transition leads from any state back to S_WAIT_START and raises the resend request.

Top module: `ps2_host_rx`

## Requirements
- R1: A frame made of a low start bit, eight data bits (least significant bit first), an odd parity bit and a high stop bit gives rx_byte equal to the data bits, with rx_par_err low. On the stop-bit edge, rx_valid goes high for one cycle.
- R2: A high data line on the edge expected to carry the start bit raises resend_req. No byte is delivered and the receiver keeps waiting for a start bit.
- R3: A low stop bit raises resend_req and delivers nothing.
- R4: With write_en high, a frame whose data ones plus parity bit add up to an even count is delivered with rx_par_err high.
- R5: With write_en low, such a parity fault raises resend_req at the parity bit, and the frame is not delivered.
- R6: A falling edge less than 39 us after the previous accepted edge is ignored. It neither advances nor disturbs the frame.
- R7: A falling edge more than 120 us after the previous accepted edge, while a frame is under way, raises resend_req and discards the partial frame. The elapsed-time counter saturates and does not wrap.
- R8: A falling edge less than 39 us after a tx_end pulse is ignored.
- R9: With write_en low, a received 0xFE raises resend_req, and a received 0xFA is dropped with no valid pulse and no resend. With write_en high, both bytes are delivered.
- R10: After a delivery or a fault, the bit position and the assembled byte return to zero, so the next frame decodes from a clean state.
- R11: During and right after reset, rx_valid, resend_req, rx_byte and rx_par_err are all zero.
- R12: rx_valid and resend_req are single-cycle pulses that never occur together. rx_byte changes only in a cycle where rx_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse once per microsecond |
| dev_clk_i | input | 1 | Raw device clock line level |
| dev_dat_i | input | 1 | Raw device data line level |
| tx_end | input | 1 | One-cycle pulse when a host-to-device transfer has finished |
| write_en | input | 1 | High when the host is permitted to write to the device |
| rx_byte | output | 8 | Last delivered byte, held between deliveries |
| rx_valid | output | 1 | One-cycle pulse marking a new rx_byte |
| rx_par_err | output | 1 | Parity-fault flag belonging to rx_byte |
| resend_req | output | 1 | One-cycle request to send the resend command |

## Verification
The late-edge timeout and the start-of-frame decode both act on the same falling edge. An edge that arrives long after a stalled partial frame is accepted by the spacing filter, yet it must end the old frame as a fault and must not be read as a fresh start bit. The bench provokes this by stopping a frame after its third data bit, idling for 200 us, and then sending one more edge followed by a complete frame. It passes the case only if exactly one resend request appears and the following frame is delivered with its own byte, which shows that the timeout took priority in that cycle and left the receiver clean.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
    localparam int DATA_BITS = 8;
    localparam int IDX_W     = $clog2(DATA_BITS);

    localparam logic [DATA_BITS-1:0] DEV_ACK_CODE  = 8'hFA;
    localparam logic [DATA_BITS-1:0] DEV_NACK_CODE = 8'hFE;

    typedef enum logic [1:0] {
        S_WAIT_START  = 2'd0,
        S_TAKE_DATA   = 2'd1,
        S_TAKE_PARITY = 2'd2,
        S_TAKE_STOP   = 2'd3
    } rx_state_e;
endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= '1;
                end else begin
                    if (s == 0) chain_q[s] <= d_in;
                    else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/ps2rx_gap.sv
module ps2rx_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [GAP_W-1:0] gap
);
    localparam logic [GAP_W-1:0] SAT = '1;

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= SAT;
        end else if (clr) begin
            gap_q <= '0;
        end else if (tick && gap_q != SAT) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    assign gap = gap_q;

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q == SAT && !clr) |=> (gap_q == SAT));
endmodule

// File: rtl/ps2rx_fsm.sv
module ps2rx_fsm
    import ps2rx_pkg::*;
#(
    parameter int GAP_W   = 8,
    parameter int MIN_GAP = 39,
    parameter int MAX_GAP = 120
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall,
    input  logic                 dat,
    input  logic [GAP_W-1:0]     edge_gap,
    input  logic [GAP_W-1:0]     tx_gap,
    input  logic                 write_en,
    output logic                 accept,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_par_err,
    output logic                 resend_req
);
    localparam logic [GAP_W-1:0] MIN_L    = GAP_W'(MIN_GAP);
    localparam logic [GAP_W-1:0] MAX_L    = GAP_W'(MAX_GAP);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS-1);

    rx_state_e            state_q, state_n;
    logic [IDX_W-1:0]     idx_q, idx_n;
    logic [DATA_BITS-1:0] byte_q, byte_n;
    logic                 par_q, par_n;
    logic                 fail, deliver;
    logic                 tx_block, late, glitch, par_bad;

    assign tx_block = (tx_gap < MIN_L);
    assign glitch   = (edge_gap < MIN_L);
    assign late     = (state_q != S_WAIT_START) && (edge_gap > MAX_L);
    assign par_bad  = ~((^byte_q) ^ dat);

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        byte_n  = byte_q;
        par_n   = par_q;
        accept  = 1'b0;
        fail    = 1'b0;
        deliver = 1'b0;
        if (fall && !tx_block) begin
            if (late) begin
                fail = 1'b1;
            end else if (!glitch) begin
                accept = 1'b1;
                unique case (state_q)
                    S_WAIT_START: begin
                        if (dat) begin
                            fail = 1'b1;
                        end else begin
                            state_n = S_TAKE_DATA;
                            idx_n   = '0;
                            byte_n  = '0;
                            par_n   = 1'b0;
                        end
                    end
                    S_TAKE_DATA: begin
                        byte_n[idx_q] = dat;
                        if (idx_q == IDX_LAST) state_n = S_TAKE_PARITY;
                        else                   idx_n   = idx_q + 1'b1;
                    end
                    S_TAKE_PARITY: begin
                        if (par_bad && !write_en) begin
                            fail = 1'b1;
                        end else begin
                            par_n   = par_bad;
                            state_n = S_TAKE_STOP;
                        end
                    end
                    S_TAKE_STOP: begin
                        if (!dat) begin
                            fail = 1'b1;
                        end else if (!write_en && byte_q == DEV_NACK_CODE) begin
                            fail = 1'b1;
                        end else begin
                            deliver = write_en || (byte_q != DEV_ACK_CODE);
                            state_n = S_WAIT_START;
                            idx_n   = '0;
                            byte_n  = '0;
                            par_n   = 1'b0;
                        end
                    end
                    default: fail = 1'b1;
                endcase
            end
        end
        if (fail) begin
            state_n = S_WAIT_START;
            idx_n   = '0;
            byte_n  = '0;
            par_n   = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_WAIT_START;
            idx_q   <= '0;
            byte_q  <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            byte_q  <= byte_n;
            par_q   <= par_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_par_err <= 1'b0;
            rx_valid   <= 1'b0;
            resend_req <= 1'b0;
        end else begin
            rx_valid   <= deliver;
            resend_req <= fail;
            if (deliver) begin
                rx_byte    <= byte_q;
                rx_par_err <= par_q;
            end
        end
    end

    // R6
    glitch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_gap < MIN_L) |=> ($stable(state_q) && $stable(idx_q) && !rx_valid && !resend_req));

    // R7
    late_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && !(tx_gap < MIN_L) && state_q != S_WAIT_START && edge_gap > MAX_L)
        |=> (resend_req && state_q == S_WAIT_START));

    // R8
    tx_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gap < MIN_L) |=> (!rx_valid && !resend_req && $stable(state_q)));

    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R12
    resend_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resend_req |=> !resend_req);

    // R12
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && resend_req));

    // R12
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_valid);
endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_W       = 8,
    parameter int MIN_GAP_US  = 39,
    parameter int MAX_GAP_US  = 120
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_us,
    input  logic                 dev_clk_i,
    input  logic                 dev_dat_i,
    input  logic                 tx_end,
    input  logic                 write_en,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 rx_par_err,
    output logic                 resend_req
);
    logic [1:0]       lines_s;
    logic             clk_s, dat_s, clk_prev_q, fall;
    logic             accept;
    logic [GAP_W-1:0] edge_gap, tx_gap;

    ps2rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({dev_dat_i, dev_clk_i}),
        .d_out (lines_s)
    );

    assign clk_s = lines_s[0];
    assign dat_s = lines_s[1];

    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev_q <= 1'b1;
        else        clk_prev_q <= clk_s;
    end

    assign fall = clk_prev_q && !clk_s;

    ps2rx_gap #(.GAP_W(GAP_W)) u_edge_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .clr   (accept),
        .gap   (edge_gap)
    );

    ps2rx_gap #(.GAP_W(GAP_W)) u_tx_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .clr   (tx_end),
        .gap   (tx_gap)
    );

    ps2rx_fsm #(
        .GAP_W   (GAP_W),
        .MIN_GAP (MIN_GAP_US),
        .MAX_GAP (MAX_GAP_US)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall       (fall),
        .dat        (dat_s),
        .edge_gap   (edge_gap),
        .tx_gap     (tx_gap),
        .write_en   (write_en),
        .accept     (accept),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .resend_req (resend_req)
    );
endmodule

// File: tb/ps2_host_rx_test.sv
`timescale 1ns/1ps
module ps2_host_rx_test;
    localparam int TICK_DIV = 2;
    localparam int NVEC     = 13;
    // {byte[17:10], par_bad[9], start[8], stop[7], wr_en[6], exp_v[5], exp_par[4], exp_rs[3:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},   // R1
        {8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0},   // R1
        {8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},   // R10
        {8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0},   // R1
        {8'h5A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0},   // R4
        {8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},   // R5
        {8'hFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd11},  // R2
        {8'h42, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1},   // R3
        {8'hFE, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},   // R9
        {8'hFA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},   // R9
        {8'hFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},   // R9
        {8'hFA, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},   // R9
        {8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0}    // R10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_us = 1'b0;
    logic       dev_clk_i = 1'b1;
    logic       dev_dat_i = 1'b1;
    logic       tx_end = 1'b0;
    logic       write_en = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_par_err, resend_req;

    int checks = 0;
    int errors = 0;
    int vcnt = 0, rcnt = 0;
    int vrun = 0, rrun = 0, vrun_max = 0, rrun_max = 0;
    int hold_bad = 0;
    logic [7:0] last_byte = 8'h00, prev_byte = 8'h00;
    logic       last_par = 1'b0;
    int tdiv = 0;

    always #2.5 clk = ~clk;

    ps2_host_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_us    (tick_us),
        .dev_clk_i  (dev_clk_i),
        .dev_dat_i  (dev_dat_i),
        .tx_end     (tx_end),
        .write_en   (write_en),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_par_err (rx_par_err),
        .resend_req (resend_req)
    );

    always @(posedge clk) begin
        if (tdiv == TICK_DIV-1) begin tdiv <= 0; tick_us <= 1'b1; end
        else begin tdiv <= tdiv + 1; tick_us <= 1'b0; end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                vcnt = vcnt + 1; last_byte = rx_byte; last_par = rx_par_err; vrun = vrun + 1;
            end else vrun = 0;
            if (resend_req) begin rcnt = rcnt + 1; rrun = rrun + 1; end
            else rrun = 0;
            if (vrun > vrun_max) vrun_max = vrun;
            if (rrun > rrun_max) rrun_max = rrun;
            if (rx_valid && resend_req) hold_bad = hold_bad + 1;
            if (rx_byte != prev_byte && !rx_valid) hold_bad = hold_bad + 1;
            prev_byte = rx_byte;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (n*TICK_DIV) @(negedge clk);
    endtask

    task automatic send_bit(input logic d, input int hi, input int lo);
        dev_dat_i = d;
        wait_us(hi);
        dev_clk_i = 1'b0;
        wait_us(lo);
        dev_clk_i = 1'b1;
    endtask

    task automatic send_range(input logic [7:0] b, input int from, input int upto);
        for (int i = from; i <= upto; i++) send_bit(b[i], 40, 40);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic pb, input logic st, input logic sp);
        send_bit(st, 40, 40);
        send_range(b, 0, 7);
        send_bit(~(^b) ^ pb, 40, 40);
        send_bit(sp, 40, 40);
        dev_dat_i = 1'b1;
        wait_us(200);
    endtask

    task automatic expect_result(input string req, input int v0, input int r0, input int ev,
                                 input int er, input logic [7:0] eb, input logic ep);
        chk((vcnt - v0) == ev, req, vcnt - v0, ev);
        chk((rcnt - r0) == er, req, rcnt - r0, er);
        if (ev > 0) begin
            chk(last_byte == eb, req, last_byte, eb);
            chk(last_par == ep, req, last_par, ep);
        end
    endtask

    task automatic finish_run();
        chk(vrun_max <= 1 && rrun_max <= 1, "R12 pulse width", vrun_max*16 + rrun_max, 17);
        chk(hold_bad == 0, "R12 hold/overlap", hold_bad, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v0, r0;
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(rx_valid == 0 && resend_req == 0, "R11 pulses in reset", {rx_valid, resend_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rx_byte == 0 && rx_par_err == 0 && rx_valid == 0 && resend_req == 0,
            "R11 after reset", {rx_byte, rx_par_err, rx_valid, resend_req}, 0);
        wait_us(200);

        for (int k = 0; k < NVEC; k++) begin
            logic [17:0] e;
            e = VEC[k];
            write_en = e[6];
            v0 = vcnt; r0 = rcnt;
            send_frame(e[17:10], e[9], e[8], e[7]);
            expect_result($sformatf("vec%0d R1..R10", k), v0, r0, int'(e[5]), int'(e[3:0]),
                          e[17:10], e[4]);
        end
        write_en = 1'b1;

        // R6: glitch edge 10 us after an accepted edge is ignored
        v0 = vcnt; r0 = rcnt;
        send_bit(1'b0, 40, 40);
        send_range(8'hC3, 0, 2);
        send_bit(1'b0, 40, 5);          // bit 3 of C3
        send_bit(1'b1, 5, 35);          // glitch with opposite data
        send_range(8'hC3, 4, 7);
        send_bit(~(^8'hC3), 40, 40);
        send_bit(1'b1, 40, 40);
        wait_us(200);
        expect_result("R6 glitch", v0, r0, 1, 0, 8'hC3, 1'b0);

        // R7 boundary: a 115 us bit spacing stays inside the window
        v0 = vcnt; r0 = rcnt;
        send_bit(1'b0, 40, 40);
        send_range(8'h6D, 0, 3);
        send_bit(1'b0, 75, 40);         // bit 4 of 6D after 115 us
        send_range(8'h6D, 5, 7);
        send_bit(~(^8'h6D), 40, 40);
        send_bit(1'b1, 40, 40);
        wait_us(200);
        expect_result("R7 slow edge", v0, r0, 1, 0, 8'h6D, 1'b0);

        // R7 + R10: stall mid-frame; the late edge is a fault, not a start
        v0 = vcnt; r0 = rcnt;
        send_bit(1'b0, 40, 40);
        send_range(8'h0F, 0, 2);
        wait_us(160);
        send_bit(1'b0, 40, 40);
        wait_us(200);
        expect_result("R7 timeout", v0, r0, 0, 1, 8'h00, 1'b0);
        v0 = vcnt; r0 = rcnt;
        send_frame(8'h96, 1'b0, 1'b0, 1'b1);
        expect_result("R10 after timeout", v0, r0, 1, 0, 8'h96, 1'b0);

        // R8: edge soon after host transmission end is ignored
        v0 = vcnt; r0 = rcnt;
        tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
        send_bit(1'b1, 10, 40);         // bad start bit if it were accepted
        wait_us(100);
        expect_result("R8 guard", v0, r0, 0, 0, 8'h00, 1'b0);
        v0 = vcnt; r0 = rcnt;
        send_frame(8'h33, 1'b0, 1'b0, 1'b1);
        expect_result("R8 frame after guard", v0, r0, 1, 0, 8'h33, 1'b0);

        finish_run();
    end
endmodule